// File: doc/BRIEF.md
# Dual-Mode Processor Counter/Timer Bank

This block holds one timer channel per processor plus a shared mode word that picks how each channel behaves. In counter mode a channel is an interval timer. A 31-bit count climbs in steps of 0x200 toward a programmed limit. When it gets there the count folds back to zero, a reached flag is set and the channel's interrupt line is raised. In user mode the same channel becomes a 63-bit count spread over two 32-bit words. Software starts and stops it, and it never interrupts. Changing the mode has defined side effects.

Software reaches the block through a 32-bit word register port with a one-cycle read latency. Byte address bits [4:0] give the offset within a window, and the bits above them give the window. Window 0 is the system window, and its only register is the mode word at offset 0x10. Window c+1 belongs to channel c. Word offsets 0x0, 0x4, 0x8 and 0xC select the limit/upper word, the count/lower word, the keep-count limit and the run flag. A shared tick enable advances every running channel by one step. The prescaler that makes the tick and the interrupt routing sit outside the block.

Top module: `proc_timer_bank`

## Requirements
- R1: After reset the mode word reads 0, and every channel is in counter mode. Each channel reads run flag 1 at offset 0xC, limit 0 and count 0, and its interrupt is low.
- R2: In counter mode each tick adds 0x200 to the count. When the incremented value would reach a nonzero limit, the count returns to 0 and the reached flag and the interrupt are set. The reached flag is bit 31 of the word read at 0x4. A write at 0x0 stores the written value AND 0x7FFFFE00 as the limit, zeroes the count and lowers the interrupt.
- R3: In counter mode a read at 0x0 returns the limit and clears both the reached flag and the interrupt.
- R4: In counter mode a limit of 0 makes the count free-run and wrap after 0x7FFFFC00 with no reached flag and no interrupt.
- R5: In counter mode a write at 0x8 sets the limit with the same mask and leaves the count alone. Writes at 0x4 have no effect. The run flag does not stop counting.
- R6: In user mode a read at 0x0 returns the reached flag in bit 31 above count bits 62:32. A read at 0x4 returns count bits 31:0, with bits 8:0 always zero. Neither read clears the reached flag.
- R7: In user mode a write at 0x0 loads count bits 62:32 from data bits 30:0. A write at 0x4 loads count bits 31:9 from data bits 31:9. Both writes clear the reached flag.
- R8: In user mode, while the run flag is 1, each tick adds 0x200, carrying from the lower word into the upper word. The tick after the count reaches 0x7FFFFFFFFFFFFC00 wraps the count to 0 and sets the reached flag. The interrupt stays low in user mode.
- R9: A write at 0xC stores data bit 0 as the run flag, and a read there returns it in bit 0 with all other bits 0. In user mode a run flag of 0 freezes the count.
- R10: Bit c of the mode word (window 0, offset 0x10) selects user mode for channel c. Bits at and above NUM_CPUS read as 0 and ignore writes. Every other offset in any window reads as 0.
- R11: When a channel enters user mode, its interrupt drops and its count, reached flag and stored interval limit are cleared. It then counts only if its run flag is 1.
- R12: When a channel returns to counter mode, its count restarts from 0 and advances on every tick regardless of the run flag, with the limit left at 0.
- R13: Read data appears with rdValid one cycle after rdEn, and rdValid is low in cycles that follow no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | One count step for every running channel |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| regAddr | input | $clog2(NUM_CPUS+1)+5 | Byte address: window above bit 5, offset in bits 4:0 |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, valid with rdValid |
| rdValid | output | 1 | Read data valid, one cycle after rdEn |
| irq | output | NUM_CPUS | Per-channel interrupt, counter mode only |

## Verification
The hardest state to reach from the ports is the 63-bit wrap in user mode. Ticking up to it would take 2^54 steps. The stimulus instead loads both halves of the count to within four steps of the top and then ticks across the boundary. It then loads the lower word to all ones to cross a carry into the upper word. The mode transitions need care too. An interrupt is raised first, so that entering user mode has something to drop. The run flag is cleared first, so that both the halt on entry and the unconditional restart on exit show up in the count.

// File: rtl/ptimer_pkg.sv
package ptimer_pkg;
  localparam int WORD_W   = 32;
  localparam int FRAC_W   = 9;                 // count bits below the step that are always zero
  localparam int LIM_W    = WORD_W - 1 - FRAC_W; // counter-mode limit/count in step units
  localparam int LO_UNITS = WORD_W - FRAC_W;     // step units held in the lower user word
  localparam int CNT_W    = 2 * WORD_W - 1 - FRAC_W; // 63-bit user count in step units
  localparam logic [CNT_W-1:0] USER_TOP = '1;
  localparam logic [LIM_W-1:0] FREE_TOP = '1;
  localparam logic [4:0] MODE_OFF = 5'h10;

  typedef enum logic [1:0] {
    W_LIMIT = 2'd0,
    W_COUNT = 2'd1,
    W_KEEP  = 2'd2,
    W_RUN   = 2'd3
  } wordSel_e;

  typedef struct packed {
    logic wrLimit;
    logic wrLimitKeep;
    logic wrHi;
    logic wrLo;
    logic wrRun;
    logic rdLimit;
    logic enterUser;
    logic leaveUser;
    logic tick;
  } chanStrobe_t;
endpackage

// File: rtl/ptc_ctrl.sv
module ptc_ctrl
  import ptimer_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        modeIn,
  input  logic        selChan,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic [4:0]  offset,
  input  logic        tickEn,
  input  logic        runQ,
  output logic        userQ,
  output chanStrobe_t strobe
);
  logic hit;
  logic wrHit;
  logic rdHit;
  logic switching;
  wordSel_e wordIdx;

  always_ff @(posedge clk) begin
    if (!rstN) userQ <= 1'b0;
    else       userQ <= modeIn;
  end

  assign hit       = selChan && !offset[4] && (offset[1:0] == 2'b00);
  assign wrHit     = wrEn && hit;
  assign rdHit     = rdEn && hit;
  assign wordIdx   = wordSel_e'(offset[3:2]);
  assign switching = modeIn ^ userQ;

  always_comb begin
    strobe = '0;
    strobe.enterUser = modeIn && !userQ;
    strobe.leaveUser = !modeIn && userQ;
    if (!switching) begin
      unique case (wordIdx)
        W_LIMIT: begin
          strobe.wrHi    = wrHit && userQ;
          strobe.wrLimit = wrHit && !userQ;
          strobe.rdLimit = rdHit && !userQ;
        end
        W_COUNT: strobe.wrLo        = wrHit && userQ;
        W_KEEP:  strobe.wrLimitKeep = wrHit && !userQ;
        W_RUN:   strobe.wrRun       = wrHit;
        default: ;
      endcase
      strobe.tick = tickEn && (!userQ || runQ);
    end
  end
endmodule

// File: rtl/ptc_datapath.sv
module ptc_datapath
  import ptimer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  chanStrobe_t       strobe,
  input  logic              userQ,
  input  logic [WORD_W-1:0] wrData,
  input  logic [1:0]        wordIdx,
  output logic              runQ,
  output logic              irqQ,
  output logic [WORD_W-1:0] rdWord
);
  logic [CNT_W-1:0] cntQ;
  logic [LIM_W-1:0] limQ;
  logic             reachedQ;
  logic [CNT_W:0]   cntInc;
  logic [CNT_W:0]   wrapAt;
  logic             wrapNow;
  logic             flagOnWrap;

  assign cntInc = {1'b0, cntQ} + 1'b1;

  always_comb begin
    if (userQ) begin
      wrapAt     = {1'b0, USER_TOP};
      flagOnWrap = 1'b1;
    end else begin
      wrapAt     = (CNT_W+1)'((limQ == '0) ? FREE_TOP : limQ);
      flagOnWrap = (limQ != '0);
    end
    wrapNow = (cntInc >= wrapAt);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ     <= '0;
      limQ     <= '0;
      reachedQ <= 1'b0;
      runQ     <= 1'b1;
      irqQ     <= 1'b0;
    end else if (strobe.enterUser) begin
      cntQ     <= '0;
      limQ     <= '0;
      reachedQ <= 1'b0;
      irqQ     <= 1'b0;
    end else if (strobe.leaveUser) begin
      cntQ     <= '0;
      reachedQ <= 1'b0;
    end else begin
      if (strobe.wrRun) runQ <= wrData[0];
      if (strobe.rdLimit) begin
        reachedQ <= 1'b0;
        irqQ     <= 1'b0;
      end
      if (strobe.wrLimit) begin
        limQ <= wrData[WORD_W-2:FRAC_W];
        cntQ <= '0;
        irqQ <= 1'b0;
      end else if (strobe.wrLimitKeep) begin
        limQ <= wrData[WORD_W-2:FRAC_W];
      end else if (strobe.wrHi) begin
        cntQ[CNT_W-1:LO_UNITS] <= wrData[WORD_W-2:0];
        reachedQ <= 1'b0;
      end else if (strobe.wrLo) begin
        cntQ[LO_UNITS-1:0] <= wrData[WORD_W-1:FRAC_W];
        reachedQ <= 1'b0;
      end else if (strobe.tick) begin
        if (wrapNow) begin
          cntQ <= '0;
          if (flagOnWrap) begin
            reachedQ <= 1'b1;
            irqQ     <= !userQ;
          end
        end else begin
          cntQ <= cntInc[CNT_W-1:0];
        end
      end
    end
  end

  always_comb begin
    unique case (wordSel_e'(wordIdx))
      W_LIMIT: rdWord = userQ ? {reachedQ, cntQ[CNT_W-1:LO_UNITS]}
                              : {1'b0, limQ, FRAC_W'(0)};
      W_COUNT: rdWord = userQ ? {cntQ[LO_UNITS-1:0], FRAC_W'(0)}
                              : {reachedQ, cntQ[LIM_W-1:0], FRAC_W'(0)};
      W_RUN:   rdWord = {{(WORD_W-1){1'b0}}, runQ};
      default: rdWord = '0;
    endcase
  end
endmodule

// File: rtl/proc_timer_bank.sv
module proc_timer_bank
  import ptimer_pkg::*;
#(
  parameter int NUM_CPUS = 2,
  localparam int WIN_W  = $clog2(NUM_CPUS + 1),
  localparam int ADDR_W = WIN_W + 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tickEn,
  input  logic                wrEn,
  input  logic                rdEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [WORD_W-1:0]   wrData,
  output logic [WORD_W-1:0]   rdData,
  output logic                rdValid,
  output logic [NUM_CPUS-1:0] irq
);
  logic [WIN_W-1:0]    win;
  logic [4:0]          off;
  logic [NUM_CPUS-1:0] modeQ;
  logic [WORD_W-1:0]   chanWord [NUM_CPUS];
  logic [WORD_W-1:0]   rdNext;

  assign win = regAddr[ADDR_W-1:5];
  assign off = regAddr[4:0];

  always_ff @(posedge clk) begin
    if (!rstN) modeQ <= '0;
    else if (wrEn && win == '0 && off == MODE_OFF) modeQ <= wrData[NUM_CPUS-1:0];
  end

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_chan
    chanStrobe_t strobe;
    logic        userQ;
    logic        runQ;
    logic        sel;

    assign sel = (win == WIN_W'(c + 1));

    ptc_ctrl ctrl_i (
      .clk(clk), .rstN(rstN), .modeIn(modeQ[c]), .selChan(sel),
      .wrEn(wrEn), .rdEn(rdEn), .offset(off), .tickEn(tickEn),
      .runQ(runQ), .userQ(userQ), .strobe(strobe)
    );

    ptc_datapath dp_i (
      .clk(clk), .rstN(rstN), .strobe(strobe), .userQ(userQ),
      .wrData(wrData), .wordIdx(off[3:2]), .runQ(runQ),
      .irqQ(irq[c]), .rdWord(chanWord[c])
    );
  end

  always_comb begin
    rdNext = '0;
    if (win == '0 && off == MODE_OFF) rdNext = WORD_W'(modeQ);
    for (int c = 0; c < NUM_CPUS; c++) begin
      if (win == WIN_W'(c + 1) && !off[4] && off[1:0] == 2'b00) rdNext = chanWord[c];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= rdEn;
      if (rdEn) rdData <= rdNext;
    end
  end
endmodule

// File: rtl/proc_timer_bank_chk.sv
module proc_timer_bank_chk #(
  parameter int NUM_CPUS = 2,
  localparam int WIN_W  = $clog2(NUM_CPUS + 1),
  localparam int ADDR_W = WIN_W + 5
) (
  input logic                clk,
  input logic                rstN,
  input logic                tickEn,
  input logic                rdEn,
  input logic [ADDR_W-1:0]   regAddr,
  input logic [31:0]         rdData,
  input logic                rdValid,
  input logic [NUM_CPUS-1:0] irq,
  input logic [NUM_CPUS-1:0] modeQ
);
  localparam logic [ADDR_W-1:0] MODE_ADDR = ADDR_W'(5'h10);

  AST_MODE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    rdValid && $past(rdEn && regAddr == MODE_ADDR) |-> (rdData >> NUM_CPUS) == '0); // R10

  AST_STATUS_SHAPE: assert property (@(posedge clk) disable iff (!rstN)
    rdValid && $past(rdEn && regAddr[4:0] == 5'h0C && regAddr[ADDR_W-1:5] != '0)
      |-> rdData[31:1] == '0); // R9

  for (genvar i = 0; i < NUM_CPUS; i++) begin : g_ch
    AST_USER_NO_IRQ: assert property (@(posedge clk) disable iff (!rstN)
      modeQ[i] && $past(modeQ[i]) |-> !irq[i]); // R8

    AST_LIMIT_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
      $past(rdEn && !tickEn && !modeQ[i] && regAddr == ADDR_W'((i + 1) * 32)) |-> !irq[i]); // R3

    AST_IRQ_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
      $rose(irq[i]) |-> $past(tickEn)); // R2
  end
endmodule

bind proc_timer_bank proc_timer_bank_chk #(.NUM_CPUS(NUM_CPUS)) chk_i (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .rdEn(rdEn), .regAddr(regAddr),
  .rdData(rdData), .rdValid(rdValid), .irq(irq), .modeQ(modeQ)
);

// File: tb/proc_timer_bank_tb_top.sv
`timescale 1ns/1ps
module proc_timer_bank_tb_top;
  localparam int NCPU   = 2;
  localparam int ADDR_W = $clog2(NCPU + 1) + 5;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              tickEn = 1'b0;
  logic              wrEn = 1'b0;
  logic              rdEn = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic [31:0]       wrData = '0;
  logic [31:0]       rdData;
  logic              rdValid;
  logic [NCPU-1:0]   irq;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic [31:0] expQ[$];
  string       tagQ[$];

  always #2 clk = ~clk;

  proc_timer_bank #(.NUM_CPUS(NCPU)) dut_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .rdEn(rdEn),
    .regAddr(regAddr), .wrData(wrData), .rdData(rdData), .rdValid(rdValid), .irq(irq)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; regAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doRead(input logic [ADDR_W-1:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    rdEn = 1'b1; regAddr = a;
    expQ.push_back(e); tagQ.push_back(tag);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tickEn = 1'b1;
    repeat (n) @(negedge clk);
    tickEn = 1'b0;
  endtask

  // Monitor: pops the expected item for each returned read.
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R13 unexpected rdValid", rdData, 32'h0);
      end else begin
        logic [31:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(rdData === e, t, rdData, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(irq === 2'b00, "R1 irq after reset", 32'(irq), 32'h0);
    check(rdValid === 1'b0, "R13 rdValid idle", 32'(rdValid), 32'h0);
    doRead(7'h10, 32'h0, "R1 mode word reset");
    doRead(7'h2C, 32'h1, "R1 ch0 run flag reset");
    doRead(7'h4C, 32'h1, "R1 ch1 run flag reset");
    doRead(7'h20, 32'h0, "R1 ch0 limit reset");
    doRead(7'h24, 32'h0, "R1 ch0 count reset");

    // Counter mode interval
    doWrite(7'h20, 32'h8000_0BFF);
    doRead(7'h20, 32'h0000_0A00, "R2 limit mask");
    ticks(3);
    doRead(7'h24, 32'h0000_0600, "R2 count steps");
    ticks(2);
    check(irq[0] === 1'b1, "R2 irq on limit", 32'(irq[0]), 32'h1);
    doRead(7'h24, 32'h8000_0000, "R2 reached and wrap");
    doRead(7'h20, 32'h0000_0A00, "R3 limit read");
    check(irq[0] === 1'b0, "R3 irq cleared by limit read", 32'(irq[0]), 32'h0);
    doRead(7'h24, 32'h0, "R3 reached cleared");

    // Free run and keep-count limit
    doWrite(7'h28, 32'h0);
    ticks(10);
    doRead(7'h24, 32'h0000_1400, "R4 free run count");
    check(irq[0] === 1'b0, "R4 no irq free run", 32'(irq[0]), 32'h0);
    doWrite(7'h28, 32'h0000_3000);
    doRead(7'h24, 32'h0000_1400, "R5 keep count on 0x8");
    doRead(7'h20, 32'h0000_3000, "R5 limit via 0x8");
    doWrite(7'h24, 32'h1234_5600);
    doRead(7'h24, 32'h0000_1400, "R5 count write ignored");
    doWrite(7'h2C, 32'h0);
    doRead(7'h2C, 32'h0, "R9 run flag stored");
    ticks(2);
    doRead(7'h24, 32'h0000_1800, "R5 counts with run clear");

    // Raise irq, then enter user mode with run clear
    doWrite(7'h28, 32'h0000_1A00);
    ticks(1);
    check(irq[0] === 1'b1, "R2 irq after keep-limit", 32'(irq[0]), 32'h1);
    doWrite(7'h10, 32'h1);
    doRead(7'h10, 32'h1, "R10 mode word");
    check(irq[0] === 1'b0, "R11 irq dropped on entry", 32'(irq[0]), 32'h0);
    doRead(7'h24, 32'h0, "R11 count cleared");
    doRead(7'h20, 32'h0, "R11 reached cleared");
    ticks(5);
    doRead(7'h24, 32'h0, "R11 halted with run clear");

    // User mode loads and top wrap
    doWrite(7'h20, 32'hFFFF_FFFF);
    doWrite(7'h24, 32'hFFFF_F9FF);
    doRead(7'h24, 32'hFFFF_F800, "R7 lower word load");
    doRead(7'h20, 32'h7FFF_FFFF, "R7 upper word load");
    doWrite(7'h2C, 32'h1);
    ticks(2);
    doRead(7'h24, 32'hFFFF_FC00, "R8 user steps");
    doRead(7'h20, 32'h7FFF_FFFF, "R6 upper word");
    ticks(1);
    doRead(7'h20, 32'h8000_0000, "R8 wrap sets reached");
    doRead(7'h24, 32'h0, "R8 wrap to zero");
    check(irq[0] === 1'b0, "R8 no irq in user mode", 32'(irq[0]), 32'h0);
    doRead(7'h20, 32'h8000_0000, "R6 read keeps reached");
    doWrite(7'h24, 32'hFFFF_FE00);
    doRead(7'h20, 32'h0, "R7 write clears reached");
    ticks(1);
    doRead(7'h20, 32'h1, "R8 carry into upper");
    doRead(7'h24, 32'h0, "R8 lower after carry");
    doWrite(7'h2C, 32'h0);
    ticks(3);
    doRead(7'h24, 32'h0, "R9 stop freezes lower");
    doRead(7'h20, 32'h1, "R9 stop freezes upper");

    // Back to counter mode with run clear
    doWrite(7'h10, 32'h0);
    ticks(4);
    doRead(7'h24, 32'h0000_0800, "R12 restart on exit");
    doRead(7'h20, 32'h0, "R12 limit left at zero");

    // Mode word masking and channel 1
    doWrite(7'h10, 32'hFFFF_FFFC);
    doRead(7'h10, 32'h0, "R10 upper bits ignored");
    doWrite(7'h10, 32'hFFFF_FFFE);
    doRead(7'h10, 32'h2, "R10 channel 1 select");
    ticks(3);
    doRead(7'h44, 32'h0000_0600, "R11 entry with run set counts");
    doRead(7'h24, 32'h0000_0E00, "R10 channel 0 unaffected");
    doRead(7'h48, 32'h0, "R10 spare offset");
    doRead(7'h30, 32'h0, "R10 channel offset 0x10");
    doRead(7'h00, 32'h0, "R10 system window other offset");
    repeat (3) @(negedge clk);
    check(rdValid === 1'b0, "R13 rdValid after reads", 32'(rdValid), 32'h0);
    check(expQ.size() == 0, "R13 all reads returned", 32'(expQ.size()), 32'h0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule